// File: doc/BRIEF.md
# Speculative Register Tag Table

This block is the issue-side copy of a small architectural register file in an out-of-order core. Each register is in one of two conditions. It either holds a value, or it is waiting for a value and holds the tag of the reservation station that will produce it. Instructions are issued in program order. Each read port returns either the value or the producer tag for one source register. An issued instruction that writes a destination renames that register to its own station tag. The table snoops the result broadcast bus. A waiting register takes a broadcast value only when the broadcast tag equals the tag the register currently holds, so a result from an older, superseded writer is dropped.

When a branch is mispredicted, `flush` is pulsed. A small controller then spends exactly one cycle in its restore state. During that cycle issue is refused (`iss_ready` low), broadcasts are not taken, and at its end every register is loaded from the `commit_vals` input and marked as holding a value. The controller has two states. ST_RUN is the normal state and the reset state. ST_RESTORE is the reload cycle. The transitions are: ST_RUN to ST_RESTORE on `flush`; ST_RESTORE to ST_RESTORE on `flush`; ST_RESTORE to ST_RUN when `flush` is low; ST_RUN to ST_RUN otherwise.

Top module: `spec_tag_table`

## Requirements
- R1: After reset every register holds a value, every value is 0 and `iss_ready` is 1.
- R2: An accepted issue (`iss_valid`=1, `iss_dst_we`=1, `iss_ready`=1) makes register `iss_dst_idx` read, from the next cycle on, as waiting (`rd_ready`=0) with `rd_tag` equal to `iss_tag`.
- R3: A waiting register whose tag equals `bc_tag` while `bc_valid`=1 holds `bc_value` as a value from the next cycle on.
- R4: A waiting register ignores a broadcast whose tag differs from its current tag. This includes the result of an older writer that was overtaken by a younger rename, and the register keeps waiting on the younger tag.
- R5: `flush` in a cycle makes the next cycle the restore cycle, with `iss_ready`=0. After that cycle every register holds its `commit_vals` entry as a value. The controller returns to normal unless `flush` is still high.
- R6: A rename and a broadcast that matches the register's old tag in the same cycle leave the register waiting on the new tag.
- R7: A read of a waiting register, in the same cycle as a broadcast that matches its tag, returns `rd_ready`=1 with `rd_value` equal to `bc_value`.
- R8: While `iss_ready`=0, issue requests and broadcasts change no register.
- R9: A read in the same cycle as a rename of the same register returns the state from before the rename.
- R10: A register that holds a value ignores every broadcast.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rd_idx | input | NUM_RD x IDX_W | Source register index, one per read port |
| rd_ready | output | NUM_RD | 1 when the read port returns a value |
| rd_tag | output | NUM_RD x TAG_W | Producer tag when the register is waiting |
| rd_value | output | NUM_RD x DATA_W | Value when rd_ready is 1 |
| iss_valid | input | 1 | An instruction issues this cycle |
| iss_dst_we | input | 1 | The issuing instruction writes a destination |
| iss_dst_idx | input | IDX_W | Destination register index |
| iss_tag | input | TAG_W | Station tag of the issuing instruction |
| iss_ready | output | 1 | 0 during the restore cycle, when issue is refused |
| bc_valid | input | 1 | Result broadcast valid |
| bc_tag | input | TAG_W | Tag of the broadcasting station |
| bc_value | input | DATA_W | Broadcast result |
| flush | input | 1 | Misprediction: reload the table from the committed copy |
| commit_vals | input | NUM_REGS x DATA_W | Committed register values |

## Verification
The hardest situation to reach is a stale result. An older producer's broadcast has to arrive after a younger rename of the same register, and in a separate case the rename has to land in the very cycle of the matching broadcast. Directed sequences issue two writers to one register and then broadcast the first tag. They also rename while broadcasting the old tag. Issues and broadcasts are placed inside the restore cycle, and back-to-back flushes are applied. A long run with narrow tags and few registers then makes tag collisions, bypass hits and stale results frequent. Every cycle is compared against a behavioural model.

// File: rtl/sttbl_pkg.sv
package sttbl_pkg;
    typedef enum logic [0:0] {
        ST_RUN     = 1'b0,
        ST_RESTORE = 1'b1
    } tbl_state_e;
endpackage

// File: rtl/sttbl_ctrl.sv
module sttbl_ctrl
    import sttbl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic flush,
    output logic iss_ready,
    output logic restore_now
);
    tbl_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:     state_d = flush ? ST_RESTORE : ST_RUN;
            ST_RESTORE: state_d = flush ? ST_RESTORE : ST_RUN;
            default:    state_d = ST_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    always_comb begin
        iss_ready   = 1'b1;
        restore_now = 1'b0;
        unique case (state_q)
            ST_RUN:     begin iss_ready = 1'b1; restore_now = 1'b0; end
            ST_RESTORE: begin iss_ready = 1'b0; restore_now = 1'b1; end
            default:    begin iss_ready = 1'b1; restore_now = 1'b0; end
        endcase
    end

    // R5
    flush_enters_restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (restore_now && !iss_ready));

    // R5
    restore_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (restore_now && !flush) |=> iss_ready);
endmodule

// File: rtl/sttbl_entry.sv
module sttbl_entry #(
    parameter int DATA_W = 16,
    parameter int TAG_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restore,
    input  logic [DATA_W-1:0] restore_val,
    input  logic              ren,
    input  logic [TAG_W-1:0]  ren_tag,
    input  logic              bc_valid,
    input  logic [TAG_W-1:0]  bc_tag,
    input  logic [DATA_W-1:0] bc_value,
    output logic              rdy_q,
    output logic [TAG_W-1:0]  tag_q,
    output logic [DATA_W-1:0] val_q,
    output logic              hit
);
    assign hit = bc_valid && !rdy_q && (tag_q == bc_tag);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdy_q <= 1'b1;
            tag_q <= '0;
            val_q <= '0;
        end else if (restore) begin
            rdy_q <= 1'b1;
            val_q <= restore_val;
        end else if (ren) begin
            rdy_q <= 1'b0;
            tag_q <= ren_tag;
        end else if (hit) begin
            rdy_q <= 1'b1;
            val_q <= bc_value;
        end
    end

    // R2
    rename_sets_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ren && !restore) |=> (!rdy_q && tag_q == $past(ren_tag)));

    // R3
    match_takes_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bc_valid && !rdy_q && tag_q == bc_tag && !ren && !restore)
        |=> (rdy_q && val_q == $past(bc_value)));

    // R4
    mismatch_keeps_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rdy_q && !(bc_valid && tag_q == bc_tag) && !ren && !restore)
        |=> (!rdy_q && $stable(tag_q)));

    // R6
    rename_beats_bc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ren && !restore && bc_valid && !rdy_q && tag_q == bc_tag) |=> !rdy_q);

    // R10
    ready_ignores_bc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rdy_q && !ren && !restore) |=> (rdy_q && $stable(val_q)));

    // R5
    restore_loads_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restore |=> (rdy_q && val_q == $past(restore_val)));
endmodule

// File: rtl/sttbl_rdport.sv
module sttbl_rdport #(
    parameter int NUM_REGS = 8,
    parameter int DATA_W   = 16,
    parameter int TAG_W    = 3,
    localparam int IDX_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
    input  logic [IDX_W-1:0]                 idx,
    input  logic [NUM_REGS-1:0]              ent_rdy,
    input  logic [NUM_REGS-1:0][TAG_W-1:0]   ent_tag,
    input  logic [NUM_REGS-1:0][DATA_W-1:0]  ent_val,
    input  logic [NUM_REGS-1:0]              ent_hit,
    input  logic [DATA_W-1:0]                bc_value,
    output logic                             rdy,
    output logic [TAG_W-1:0]                 tag,
    output logic [DATA_W-1:0]                val
);
    always_comb begin
        rdy = 1'b1;
        tag = '0;
        val = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (idx == IDX_W'(i)) begin
                tag = ent_tag[i];
                if (ent_rdy[i]) begin
                    rdy = 1'b1;
                    val = ent_val[i];
                end else if (ent_hit[i]) begin
                    rdy = 1'b1;
                    val = bc_value;
                end else begin
                    rdy = 1'b0;
                end
            end
        end
    end
endmodule

// File: rtl/spec_tag_table.sv
module spec_tag_table #(
    parameter int NUM_REGS = 8,
    parameter int DATA_W   = 16,
    parameter int TAG_W    = 3,
    parameter int NUM_RD   = 2,
    localparam int IDX_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [NUM_RD-1:0][IDX_W-1:0]     rd_idx,
    output logic [NUM_RD-1:0]                rd_ready,
    output logic [NUM_RD-1:0][TAG_W-1:0]     rd_tag,
    output logic [NUM_RD-1:0][DATA_W-1:0]    rd_value,
    input  logic                             iss_valid,
    input  logic                             iss_dst_we,
    input  logic [IDX_W-1:0]                 iss_dst_idx,
    input  logic [TAG_W-1:0]                 iss_tag,
    output logic                             iss_ready,
    input  logic                             bc_valid,
    input  logic [TAG_W-1:0]                 bc_tag,
    input  logic [DATA_W-1:0]                bc_value,
    input  logic                             flush,
    input  logic [NUM_REGS-1:0][DATA_W-1:0]  commit_vals
);
    logic                            restore_now;
    logic [NUM_REGS-1:0]             ent_rdy;
    logic [NUM_REGS-1:0][TAG_W-1:0]  ent_tag;
    logic [NUM_REGS-1:0][DATA_W-1:0] ent_val;
    logic [NUM_REGS-1:0]             ent_hit;
    logic [NUM_REGS-1:0]             ent_ren;
    logic                            iss_take;

    sttbl_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .flush       (flush),
        .iss_ready   (iss_ready),
        .restore_now (restore_now)
    );

    assign iss_take = iss_valid && iss_dst_we && iss_ready;

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_ent
        assign ent_ren[g] = iss_take && (iss_dst_idx == IDX_W'(g));
        sttbl_entry #(.DATA_W(DATA_W), .TAG_W(TAG_W)) u_ent (
            .clk         (clk),
            .rst_n       (rst_n),
            .restore     (restore_now),
            .restore_val (commit_vals[g]),
            .ren         (ent_ren[g]),
            .ren_tag     (iss_tag),
            .bc_valid    (bc_valid),
            .bc_tag      (bc_tag),
            .bc_value    (bc_value),
            .rdy_q       (ent_rdy[g]),
            .tag_q       (ent_tag[g]),
            .val_q       (ent_val[g]),
            .hit         (ent_hit[g])
        );
    end

    for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
        sttbl_rdport #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .TAG_W(TAG_W)) u_rd (
            .idx      (rd_idx[p]),
            .ent_rdy  (ent_rdy),
            .ent_tag  (ent_tag),
            .ent_val  (ent_val),
            .ent_hit  (ent_hit),
            .bc_value (bc_value),
            .rdy      (rd_ready[p]),
            .tag      (rd_tag[p]),
            .val      (rd_value[p])
        );
    end

    // R8
    blocked_issue_no_rename_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !iss_ready |-> (ent_ren == '0));

    // R7
    bypass_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bc_valid && !ent_rdy[rd_idx[0]] && ent_tag[rd_idx[0]] == bc_tag)
        |-> (rd_ready[0] && rd_value[0] == bc_value));
endmodule

// File: tb/spec_tag_table_tb.sv
module spec_tag_table_tb;
    localparam int NR = 8, DW = 16, TW = 3, NP = 2, IW = 3;

    logic clk = 0, rst_n = 0;
    logic [NP-1:0][IW-1:0] rd_idx;
    logic [NP-1:0] rd_ready;
    logic [NP-1:0][TW-1:0] rd_tag;
    logic [NP-1:0][DW-1:0] rd_value;
    logic iss_valid, iss_dst_we, iss_ready, bc_valid, flush;
    logic [IW-1:0] iss_dst_idx;
    logic [TW-1:0] iss_tag, bc_tag;
    logic [DW-1:0] bc_value;
    logic [NR-1:0][DW-1:0] commit_vals;

    int errors = 0, checks = 0;
    int m_rdy[NR], m_tag[NR], m_val[NR];
    bit m_rst;

    always #10 clk = ~clk;

    spec_tag_table #(.NUM_REGS(NR), .DATA_W(DW), .TAG_W(TW), .NUM_RD(NP)) u_dut (
        .clk(clk), .rst_n(rst_n), .rd_idx(rd_idx), .rd_ready(rd_ready), .rd_tag(rd_tag),
        .rd_value(rd_value), .iss_valid(iss_valid), .iss_dst_we(iss_dst_we),
        .iss_dst_idx(iss_dst_idx), .iss_tag(iss_tag), .iss_ready(iss_ready),
        .bc_valid(bc_valid), .bc_tag(bc_tag), .bc_value(bc_value), .flush(flush),
        .commit_vals(commit_vals));

    task automatic chk(string lbl, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", lbl, act, exp);
        end
    endtask

    task automatic compare(string lbl);
        chk({lbl, " iss_ready"}, int'(iss_ready), m_rst ? 0 : 1);
        if (!m_rst) begin
            for (int p = 0; p < NP; p++) begin
                int r = int'(rd_idx[p]);
                int er, ev, et;
                et = m_tag[r];
                if (m_rdy[r] != 0) begin er = 1; ev = m_val[r]; end
                else if (bc_valid && m_tag[r] == int'(bc_tag)) begin er = 1; ev = int'(bc_value); end
                else begin er = 0; ev = 0; end
                chk({lbl, " rd_ready"}, int'(rd_ready[p]), er);
                if (er != 0) chk({lbl, " rd_value"}, int'(rd_value[p]), ev);
                else         chk({lbl, " rd_tag"}, int'(rd_tag[p]), et);
            end
        end
    endtask

    task automatic update();
        if (m_rst) begin
            for (int i = 0; i < NR; i++) begin m_rdy[i] = 1; m_val[i] = int'(commit_vals[i]); end
        end else begin
            for (int i = 0; i < NR; i++) begin
                if (iss_valid && iss_dst_we && int'(iss_dst_idx) == i) begin
                    m_rdy[i] = 0; m_tag[i] = int'(iss_tag);
                end else if (m_rdy[i] == 0 && bc_valid && m_tag[i] == int'(bc_tag)) begin
                    m_rdy[i] = 1; m_val[i] = int'(bc_value);
                end
            end
        end
        m_rst = flush;
    endtask

    task automatic cyc(string lbl, bit iv, bit we, int dst, int tg, bit bv, int bt, int bval,
                       bit fl, int ra, int rb);
        iss_valid = iv; iss_dst_we = we; iss_dst_idx = IW'(dst); iss_tag = TW'(tg);
        bc_valid = bv; bc_tag = TW'(bt); bc_value = DW'(bval); flush = fl;
        rd_idx[0] = IW'(ra); rd_idx[1] = IW'(rb);
        #5;
        compare(lbl);
        @(posedge clk);
        #1;
        update();
        @(negedge clk);
    endtask

    initial begin
        #(200000 * 20);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < NR; i++) begin
            m_rdy[i] = 1; m_tag[i] = 0; m_val[i] = 0;
            commit_vals[i] = DW'(16'h1000 + i * 17);
        end
        m_rst = 0;
        iss_valid = 0; iss_dst_we = 0; iss_dst_idx = 0; iss_tag = 0;
        bc_valid = 0; bc_tag = 0; bc_value = 0; flush = 0; rd_idx = '0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset state
        cyc("R1", 0,0,0,0, 0,0,0, 0, 0,7);
        cyc("R1", 0,0,0,0, 0,0,0, 0, 3,5);
        // R2 rename, R9 same-cycle read sees old state
        cyc("R9", 1,1,3,5, 0,0,0, 0, 3,3);
        cyc("R2", 0,0,0,0, 0,0,0, 0, 3,1);
        // R7 bypass then R3 capture
        cyc("R7", 0,0,0,0, 1,5,16'h1234, 0, 3,0);
        cyc("R3", 0,0,0,0, 0,0,0, 0, 3,3);
        // R4 older writer result dropped
        cyc("R4", 1,1,1,2, 0,0,0, 0, 1,2);
        cyc("R4", 1,1,1,6, 0,0,0, 0, 1,2);
        cyc("R4", 0,0,0,0, 1,2,16'haaaa, 0, 1,1);
        cyc("R4", 0,0,0,0, 0,0,0, 0, 1,1);
        // R10 ready register ignores broadcast
        cyc("R10", 0,0,0,0, 1,0,16'hbeef, 0, 0,2);
        cyc("R10", 0,0,0,0, 0,0,0, 0, 0,2);
        // R6 rename wins over same-cycle match of old tag
        cyc("R6", 1,1,1,4, 1,6,16'h5555, 0, 1,1);
        cyc("R6", 0,0,0,0, 0,0,0, 0, 1,1);
        cyc("R3", 0,0,0,0, 1,4,16'h4444, 0, 1,1);
        cyc("R3", 0,0,0,0, 0,0,0, 0, 1,1);
        // R5 restore, R8 issue and broadcast blocked during restore
        cyc("R5", 1,1,2,1, 0,0,0, 0, 2,4);
        cyc("R5", 0,0,0,0, 0,0,0, 1, 2,4);
        cyc("R8", 1,1,4,3, 1,1,16'h7777, 0, 2,4);
        cyc("R8", 0,0,0,0, 0,0,0, 0, 2,4);
        cyc("R5", 0,0,0,0, 0,0,0, 0, 1,3);
        // R5 back-to-back flush
        cyc("R5", 1,1,0,2, 0,0,0, 1, 0,0);
        cyc("R5", 0,0,0,0, 0,0,0, 1, 0,0);
        cyc("R8", 1,1,6,2, 0,0,0, 0, 0,6);
        cyc("R5", 0,0,0,0, 0,0,0, 0, 0,6);
        // random mix
        for (int n = 0; n < 3000; n++) begin
            if (n % 97 == 0)
                for (int i = 0; i < NR; i++) commit_vals[i] = DW'($urandom);
            cyc("R2 R3 R4 R7 random",
                ($urandom % 3) != 0, ($urandom % 4) != 0, int'($urandom % NR),
                int'($urandom % (1 << TW)), ($urandom % 2) != 0,
                int'($urandom % (1 << TW)), int'($urandom % 65536),
                ($urandom % 41) == 0, int'($urandom % NR), int'($urandom % NR));
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule